// File: doc/BRIEF.md
# Serial Memory Power-State Sequencer

This block sequences the power state of a serial memory slave on an SPI bus. It brings the bus chip select, serial clock and data-in lines into the system clock domain. It collects the first byte of each frame and decides which power state the slave is in.

The slave idles in standby whenever it is deselected. Selecting it from standby grants access at once. Two deeper states, deep power-down and hibernate, are entered only by command. The frame must carry exactly the matching eight-bit opcode, and the command takes effect on the deselect edge. Selecting the slave again from a deep state starts a wake-up period whose length is counted in system clocks. Hibernate uses the longer count. During that period the ready flag that gates the memory core stays low, and anything shifted in is thrown away.

Top module: `spi_pwr_seq`

## Requirements
- R1: After reset the state output is standby, ready is high and waking is low. The state codes are 0 active, 1 standby, 2 deep power-down, 3 hibernate and 4 waking.
- R2: A falling chip select in standby moves the state to active with ready high on the third rising clock edge after the input changes. There is no wake-up delay, and the state has not changed by the second edge.
- R3: A frame whose first byte is 0xBA (MSB first, sampled on rising SCK while chip select is low), with exactly 8 SCK rising edges, puts the block into deep power-down with ready low once chip select rises.
- R4: A frame of exactly 8 bits carrying 0xB9 puts the block into hibernate with ready low once chip select rises.
- R5: A frame with any other first byte, or with fewer or more than 8 SCK rising edges, returns the block to standby with ready high when chip select rises.
- R6: A falling chip select in deep power-down raises waking for exactly DPD_WAKE clock cycles. Ready stays low throughout.
- R7: A falling chip select in hibernate raises waking for exactly HIB_WAKE clock cycles, and HIB_WAKE must exceed DPD_WAKE. Ready stays low throughout.
- R8: Frames shifted in during a wake-up are discarded. A 0xBA frame sent while waking leaves the block in standby, not deep power-down, whether the frame ends before or after the wake-up does.
- R9: When the wake-up ends with chip select still low, the state is active with ready high. When it ends with chip select high, the state is standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn_i | input | 1 | Chip select, active low, asynchronous |
| spi_sck_i | input | 1 | Serial clock, asynchronous |
| spi_mosi_i | input | 1 | Serial data in, asynchronous |
| pwr_state_o | output | 3 | Current power state code |
| core_ready_o | output | 1 | High when the memory core may be accessed |
| waking_o | output | 1 | High while the wake-up delay runs |

## Verification
An opcode decoded wrongly or a bit miscounted shows up as a wrong state code within three clocks of the deselect edge, so a sweep over every first-byte value and every frame length from 0 to 11 covers the decode completely. A wake counter that is off by a cycle, or loaded with the wrong length, changes the measured width of the waking pulse. A frame-discard flag that never clears or never sets shows up as a deep state that was reached, or a standby that was lost, after a frame sent during wake-up.

// File: rtl/spi_pwr_pkg.sv
package spi_pwr_pkg;
   typedef enum logic [2:0] {
      PS_ACTIVE  = 3'd0,
      PS_STANDBY = 3'd1,
      PS_DEEP    = 3'd2,
      PS_HIBER   = 3'd3,
      PS_WAKING  = 3'd4
   } pwr_state_e;
endpackage

// File: rtl/spi_pwr_sync.sv
module spi_pwr_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pwr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_pwr_opcode.sv
module spi_pwr_opcode #(
   parameter int OP_W  = 8,
   localparam int CNT_W = $clog2(OP_W + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_start_i,
   input  logic            sck_rise_i,
   input  logic            mosi_i,
   output logic [OP_W-1:0] opcode_o,
   output logic            exact_o
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(OP_W + 1);

   logic [OP_W-1:0]  shift_q;
   logic [CNT_W-1:0] bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         bits_q  <= '0;
      end else if (frame_start_i) begin
         shift_q <= '0;
         bits_q  <= '0;
      end else if (sck_rise_i) begin
         if (bits_q < CNT_W'(OP_W)) shift_q <= {shift_q[OP_W-2:0], mosi_i};
         if (bits_q != CNT_SAT)     bits_q  <= bits_q + 1'b1;
      end
   end

   assign opcode_o = shift_q;
   assign exact_o  = (bits_q == CNT_W'(OP_W));

   p_bits_saturate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bits_q <= CNT_SAT);
endmodule

// File: rtl/spi_pwr_wake_timer.sv
module spi_pwr_wake_timer #(
   parameter int DPD_WAKE = 20,
   parameter int HIB_WAKE = 50,
   localparam int CNT_W = $clog2(HIB_WAKE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic sel_hib_i,
   output logic busy_o,
   output logic done_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= sel_hib_i ? CNT_W'(HIB_WAKE - 1) : CNT_W'(DPD_WAKE - 1);
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);

   p_wake_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0 && !start_i) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
   p_wake_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !busy_q);
endmodule

// File: rtl/spi_pwr_seq.sv
module spi_pwr_seq
   import spi_pwr_pkg::*;
#(
   parameter int         DPD_WAKE    = 20,
   parameter int         HIB_WAKE    = 50,
   parameter int         SYNC_STAGES = 2,
   parameter int         OP_W        = 8,
   parameter logic [7:0] OP_DPD      = 8'hBA,
   parameter logic [7:0] OP_HIB      = 8'hB9
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       spi_csn_i,
   input  logic       spi_sck_i,
   input  logic       spi_mosi_i,
   output logic [2:0] pwr_state_o,
   output logic       core_ready_o,
   output logic       waking_o
);
   if (DPD_WAKE < 1 || HIB_WAKE <= DPD_WAKE) begin : g_bad_wake
      $error("spi_pwr_seq: need 1 <= DPD_WAKE < HIB_WAKE");
   end
   if (OP_W != 8) begin : g_bad_opw
      $error("spi_pwr_seq: opcode width must be 8");
   end

   // synchronizers: bit2 csn, bit1 sck, bit0 mosi
   logic [2:0] sync_q;
   logic       csn_prev_q, sck_prev_q;

   spi_pwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({spi_csn_i, spi_sck_i, spi_mosi_i}),
      .q_o   (sync_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_prev_q <= 1'b1;
         sck_prev_q <= 1'b0;
      end else begin
         csn_prev_q <= sync_q[2];
         sck_prev_q <= sync_q[1];
      end
   end

   logic cs_fall, cs_rise, sck_rise;
   assign cs_fall  = csn_prev_q && !sync_q[2];
   assign cs_rise  = !csn_prev_q && sync_q[2];
   assign sck_rise = !sck_prev_q && sync_q[1] && !sync_q[2];

   logic [OP_W-1:0] opcode;
   logic            exact;

   spi_pwr_opcode #(.OP_W(OP_W)) u_opcode (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (cs_fall),
      .sck_rise_i    (sck_rise),
      .mosi_i        (sync_q[0]),
      .opcode_o      (opcode),
      .exact_o       (exact)
   );

   pwr_state_e state_q, state_d;
   logic       frame_bad_q;
   logic       wake_start, wake_busy, wake_done;

   assign wake_start = cs_fall && (state_q == PS_DEEP || state_q == PS_HIBER);

   spi_pwr_wake_timer #(.DPD_WAKE(DPD_WAKE), .HIB_WAKE(HIB_WAKE)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (wake_start),
      .sel_hib_i (state_q == PS_HIBER),
      .busy_o    (wake_busy),
      .done_o    (wake_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_STANDBY: if (cs_fall) state_d = PS_ACTIVE;
         PS_ACTIVE: begin
            if (cs_rise) begin
               if (exact && !frame_bad_q && opcode == OP_DPD)      state_d = PS_DEEP;
               else if (exact && !frame_bad_q && opcode == OP_HIB) state_d = PS_HIBER;
               else                                                state_d = PS_STANDBY;
            end
         end
         PS_DEEP, PS_HIBER: if (cs_fall) state_d = PS_WAKING;
         PS_WAKING: if (wake_done) state_d = sync_q[2] ? PS_STANDBY : PS_ACTIVE;
         default: state_d = PS_STANDBY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= PS_STANDBY;
         frame_bad_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == PS_WAKING) frame_bad_q <= 1'b1;
         else if (cs_fall)         frame_bad_q <= 1'b0;
      end
   end

   assign pwr_state_o  = state_q;
   assign core_ready_o = (state_q == PS_ACTIVE) || (state_q == PS_STANDBY);
   assign waking_o     = (state_q == PS_WAKING);

   p_standby_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_STANDBY && cs_fall) |=> state_q == PS_ACTIVE);
   p_deep_needs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PS_DEEP && state_d == PS_DEEP) |-> (cs_rise && exact));
   p_hiber_needs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PS_HIBER && state_d == PS_HIBER) |-> (cs_rise && exact));
   p_wake_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_start |=> (wake_busy && state_q == PS_WAKING));
   p_no_deep_from_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PS_WAKING |=> !(state_q == PS_DEEP || state_q == PS_HIBER));
   p_wake_tracks_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_WAKING) |-> wake_busy);
endmodule

// File: tb/spi_pwr_seq_tb.sv
module spi_pwr_seq_tb;
   localparam int DPD = 12;
   localparam int HIB = 60;
   localparam int HALF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
   logic [2:0] st;
   logic rdy, wk;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   spi_pwr_seq #(.DPD_WAKE(DPD), .HIB_WAKE(HIB)) u_dut (
      .clk(clk), .rst_n(rst_n), .spi_csn_i(csn), .spi_sck_i(sck),
      .spi_mosi_i(mosi), .pwr_state_o(st), .core_ready_o(rdy), .waking_o(wk)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         mosi = (i < 8) ? v[7-i] : 1'b0;
         wait_n(HALF);
         sck = 1'b1;
         wait_n(HALF);
         sck = 1'b0;
      end
      wait_n(HALF);
   endtask

   // full frame from standby; returns state after deselect
   task automatic frame(input logic [7:0] v, input int n, output logic [2:0] res);
      csn = 1'b0;
      wait_n(5);
      send_bits(v, n);
      csn = 1'b1;
      wait_n(5);
      res = st;
   endtask

   // select from a deep state, measure waking width with select held low
   task automatic wake_measure(output int width);
      width = 0;
      csn = 1'b0;
      for (int i = 0; i < HIB + 20; i++) begin
         @(negedge clk);
         if (wk) begin
            width++;
            if (rdy) chk(1'b0, "R6 ready low while waking", 1, 0);
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] r;
      int w;
      wait_n(3);
      chk(st == 3'd1 && rdy && !wk, "R1 reset in reset", st, 1);
      rst_n = 1'b1;
      wait_n(3);
      chk(st == 3'd1, "R1 reset state", st, 1);
      chk(rdy == 1'b1, "R1 reset ready", rdy, 1);
      chk(wk == 1'b0, "R1 reset waking", wk, 0);

      // R2 exact latency
      csn = 1'b0;
      wait_n(2);
      chk(st == 3'd1, "R2 not before third edge", st, 1);
      wait_n(1);
      chk(st == 3'd0 && rdy, "R2 active at third edge", st, 0);
      csn = 1'b1;
      wait_n(5);
      chk(st == 3'd1, "R5 empty frame to standby", st, 1);

      // R3/R4/R5/R6/R7/R9 sweep over all opcodes
      for (int op = 0; op < 256; op++) begin
         logic [2:0] exp;
         exp = (op == 8'hBA) ? 3'd2 : (op == 8'hB9) ? 3'd3 : 3'd1;
         frame(8'(op), 8, r);
         if (op == 8'hBA)      chk(r == exp && !rdy, "R3 deep entry", r, exp);
         else if (op == 8'hB9) chk(r == exp && !rdy, "R4 hibernate entry", r, exp);
         else                  chk(r == exp && rdy, "R5 other opcode", r, exp);
         if (r == 3'd2 || r == 3'd3) begin
            wake_measure(w);
            if (r == 3'd2) chk(w == DPD, "R6 deep wake width", w, DPD);
            else           chk(w == HIB, "R7 hibernate wake width", w, HIB);
            chk(st == 3'd0 && rdy, "R9 active after wake, select low", st, 0);
            csn = 1'b1;
            wait_n(5);
            chk(st == 3'd1, "R5 back to standby", st, 1);
         end
      end

      // R3/R5 frame-length sweep
      for (int n = 0; n < 12; n++) begin
         logic [2:0] exp;
         exp = (n == 8) ? 3'd2 : 3'd1;
         frame(8'hBA, n, r);
         chk(r == exp, $sformatf("R5 length %0d", n), r, exp);
         if (r == 3'd2) begin
            wake_measure(w);
            csn = 1'b1;
            wait_n(5);
         end
      end

      // R9 wake ends with select high
      frame(8'hBA, 8, r);
      csn = 1'b0;
      wait_n(4);
      csn = 1'b1;
      wait_n(DPD + 10);
      chk(st == 3'd1 && rdy, "R9 standby after wake, select high", st, 1);

      // R8a: frame wholly inside hibernate wake
      frame(8'hB9, 8, r);
      csn = 1'b0;
      wait_n(6);
      chk(wk && !rdy, "R8 waking during frame", wk, 1);
      send_bits(8'hBA, 8);
      csn = 1'b1;
      wait_n(HIB + 10);
      chk(st == 3'd1, "R8 frame inside wake discarded", st, 1);

      // R8b: frame straddling end of deep wake
      frame(8'hBA, 8, r);
      csn = 1'b0;
      wait_n(5);
      send_bits(8'hBA, 8);
      chk(st == 3'd0 && rdy, "R9 active after wake mid-frame", st, 0);
      csn = 1'b1;
      wait_n(5);
      chk(st == 3'd1, "R8 straddling frame discarded", st, 1);

      // fresh frame after discard still works
      frame(8'hBA, 8, r);
      chk(r == 3'd2, "R3 entry after discarded frame", r, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule